// File: doc/BRIEF.md
# Fetch-Counting Deadman Timer

This block is a safety timer. It counts the processor's instruction-fetch pulses rather than clock cycles, so it stops advancing while the processor sleeps. If software lets the count climb to a programmed period, the block raises a timeout event and asks the reset controller for a processor reset. The reset request carries a cause bit.

Software keeps the timer alive with a two-step keyed clear. First it writes a first key to an arming register. Then it waits until the clear window opens near the end of the period. Then it writes a second key. A wrong key, a second key sent while the window is closed, or a second key sent with no first key latched sets a sticky error flag and requests a reset at once.

Registers sit on a small word-addressed bus. A write takes effect on the clock edge where it is presented. A read is combinational in the same cycle. Every access completes in one cycle and there is no back-pressure. The period and the window interval are fixed by parameters and can be read back, and the window must be smaller than the period.

Top module: `fetch_deadman`

## Requirements
- R1: After reset the enable bit, the count, every status bit, `rst_req` and `rst_cause` read 0.
- R2: While enabled, the count rises by exactly one at each clock edge where `fetch_stb` is high. Without a fetch pulse it holds its value, and while disabled it never moves.
- R3: When the enabled count equals PERIOD, then at the next edge the event flag (status bit 5), `rst_req` and `rst_cause` bit 5 go high. From then on the count stays frozen at PERIOD.
- R4: The enable bit is bit 15 of the control word at offset 0x00, which a plain write loads. A write to offset 0x04 sets only the bits written as 1, and a write to offset 0x08 clears only the bits written as 1.
- R5: A write to offset 0x10 with bits 15:8 equal to 0x40 latches the first key, whatever the other bits hold. Any other value in bits 15:8 sets the first-key error flag (status bit 7) and the event flag.
- R6: Status bit 0 (window open) reads 1 exactly when a first key is latched and the count is at least PERIOD minus WINDOW.
- R7: A write to offset 0x20 with bits 7:0 equal to 0x08 while the window is open returns the count to 0, closes the window and discards the latched first key.
- R8: A write to offset 0x20 that has the wrong value, arrives with the window closed, or arrives with no first key latched sets the second-key error flag (status bit 6) and the event flag, and raises `rst_req`.
- R9: The two error flags and the event flag stay set until reset, even when the enable bit is changed or the keys are written again.
- R10: In the cycle right after a write that turns the enable bit from 1 to 0, writes have no effect and reads return 0.
- R11: Offset 0x40 reads the count, offset 0x60 reads PERIOD and offset 0x70 reads WINDOW. Each is zero-extended.
- R12: While the enable bit is 0, writes to offsets 0x10 and 0x20 are ignored and set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_stb | input | 1 | One-cycle pulse per instruction fetch |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rst_req | output | 1 | Processor reset request, sticky until reset |
| rst_cause | output | 8 | Reset cause; bit 5 marks this timer |

## Verification
A small configuration is used, with a period of 12 and a window of 4. The bench steps through every count value from 0 to the period one fetch at a time, with a first key latched. At each step it checks the count and the window bit, which pins down exactly where the window boundary falls and on which edge the timeout lands. Keyed clears are tried in the correct order, with a wrong second-key value, with the window closed and with no first key, which separates the three ways the second step can fail. Several wrong first-key values are also tried, along with a correct key that carries junk in its unused bits. Fetch gaps, writes while disabled and an access in the cycle after a disable then show that nothing moves when it should hold.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CSET = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CCLR = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ARM  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_KICK = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_PER  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_WIN  = 8'h70;

  localparam logic [7:0] ARM_KEY  = 8'h40;
  localparam logic [7:0] KICK_KEY = 8'h08;

  localparam int EN_BIT    = 15;
  localparam int ST_WIN    = 0;
  localparam int ST_EVT    = 5;
  localparam int ST_BAD2   = 6;
  localparam int ST_BAD1   = 7;
  localparam int CAUSE_BIT = 5;

  typedef struct packed {
    logic       arm_wr;
    logic [7:0] arm_val;
    logic       kick_wr;
    logic [7:0] kick_val;
  } key_cmd_t;
endpackage

// File: rtl/fdm_ctrl.sv
module fdm_ctrl
  import fdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       wdata_lo,
  output logic              en,
  output logic              quiet,
  output logic              rd_ok,
  output key_cmd_t          cmd
);
  logic en_q, en_d, quiet_q, wr_ok;

  assign wr_ok = bus_wr & ~quiet_q;
  assign rd_ok = bus_rd & ~quiet_q;

  always_comb begin
    en_d = en_q;
    if (wr_ok) begin
      case (bus_addr)
        OFS_CTRL: en_d = wdata_lo[EN_BIT];
        OFS_CSET: if (wdata_lo[EN_BIT]) en_d = 1'b1;
        OFS_CCLR: if (wdata_lo[EN_BIT]) en_d = 1'b0;
        default:  en_d = en_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      quiet_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      quiet_q <= en_q & ~en_d;
    end
  end

  always_comb begin
    cmd.arm_wr   = wr_ok & en_q & (bus_addr == OFS_ARM);
    cmd.arm_val  = wdata_lo[15:8];
    cmd.kick_wr  = wr_ok & en_q & (bus_addr == OFS_KICK);
    cmd.kick_val = wdata_lo[7:0];
  end

  assign en    = en_q;
  assign quiet = quiet_q;
endmodule

// File: rtl/fdm_counter.sv
module fdm_counter #(
  parameter int CNT_W  = 32,
  parameter int PERIOD = 1000,
  parameter int WINDOW = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fetch_stb,
  input  logic             clear,
  input  logic             frozen,
  output logic [CNT_W-1:0] cnt,
  output logic             at_period,
  output logic             in_zone
);
  localparam logic [CNT_W-1:0] PER_C   = CNT_W'(PERIOD);
  localparam logic [CNT_W-1:0] ZONE_LO = CNT_W'(PERIOD - WINDOW);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cnt_q <= '0;
    else if (frozen)                               cnt_q <= cnt_q;
    else if (clear)                                cnt_q <= '0;
    else if (en && fetch_stb && cnt_q != PER_C)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt       = cnt_q;
  assign at_period = (cnt_q == PER_C);
  assign in_zone   = (cnt_q >= ZONE_LO);
endmodule

// File: rtl/fdm_keyseq.sv
module fdm_keyseq
  import fdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  key_cmd_t cmd,
  input  logic     timeout,
  input  logic     in_zone,
  output logic     armed,
  output logic     win_open,
  output logic     do_clear,
  output logic     bad1,
  output logic     bad2,
  output logic     evt
);
  logic armed_q, bad1_q, bad2_q, evt_q;
  logic arm_good, arm_bad, kick_good, kick_bad;

  assign win_open  = armed_q & in_zone;
  assign arm_good  = cmd.arm_wr & (cmd.arm_val == ARM_KEY);
  assign arm_bad   = cmd.arm_wr & ~arm_good;
  assign kick_good = cmd.kick_wr & (cmd.kick_val == KICK_KEY) & win_open;
  assign kick_bad  = cmd.kick_wr & ~kick_good;
  assign do_clear  = kick_good & ~evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bad1_q  <= 1'b0;
      bad2_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (kick_good)     armed_q <= 1'b0;
      else if (arm_good) armed_q <= 1'b1;
      bad1_q <= bad1_q | arm_bad;
      bad2_q <= bad2_q | kick_bad;
      evt_q  <= evt_q | timeout | arm_bad | kick_bad;
    end
  end

  assign armed = armed_q;
  assign bad1  = bad1_q;
  assign bad2  = bad2_q;
  assign evt   = evt_q;
endmodule

// File: rtl/fetch_deadman.sv
module fetch_deadman
  import fdm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PERIOD = 1000,
  parameter int WINDOW = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_stb,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic [7:0]        rst_cause
);
  logic             en, quiet, rd_ok;
  key_cmd_t         cmd;
  logic [CNT_W-1:0] cnt;
  logic             at_period, in_zone, armed, win_open, do_clear;
  logic             bad1, bad2, evt;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:16];

  fdm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .wdata_lo(bus_wdata[15:0]),
    .en(en), .quiet(quiet), .rd_ok(rd_ok), .cmd(cmd)
  );

  fdm_counter #(.CNT_W(CNT_W), .PERIOD(PERIOD), .WINDOW(WINDOW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .fetch_stb(fetch_stb),
    .clear(do_clear), .frozen(evt), .cnt(cnt),
    .at_period(at_period), .in_zone(in_zone)
  );

  fdm_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .timeout(at_period & en),
    .in_zone(in_zone), .armed(armed), .win_open(win_open),
    .do_clear(do_clear), .bad1(bad1), .bad2(bad2), .evt(evt)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata[EN_BIT] = en;
        OFS_STAT: begin
          bus_rdata[ST_WIN]  = win_open;
          bus_rdata[ST_EVT]  = evt;
          bus_rdata[ST_BAD2] = bad2;
          bus_rdata[ST_BAD1] = bad1;
        end
        OFS_CNT:  bus_rdata[CNT_W-1:0] = cnt;
        OFS_PER:  bus_rdata = DATA_W'(PERIOD);
        OFS_WIN:  bus_rdata = DATA_W'(WINDOW);
        default:  bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    rst_cause            = '0;
    rst_cause[CAUSE_BIT] = evt;
  end
  assign rst_req = evt;
endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int CNT_W  = 32,
  parameter int PERIOD = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_stb,
  input logic [CNT_W-1:0] cnt,
  input logic             en,
  input logic             quiet,
  input logic             armed,
  input logic             win_open,
  input logic             do_clear,
  input logic             bad1,
  input logic             bad2,
  input logic             evt,
  input logic             rst_req,
  input logic [7:0]       rst_cause
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PERIOD)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_stb && !do_clear) |=> $stable(cnt)); // R2
  AST_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == CNT_W'(PERIOD)) |=> (rst_req && rst_cause[5])); // R3
  AST_WIN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> armed); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (cnt == '0 && !armed)); // R7
  AST_BAD1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad1 |=> bad1); // R9
  AST_BAD2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad2 |=> (bad2 && evt)); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(en)); // R10
endmodule

bind fetch_deadman fdm_checker #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .cnt(cnt), .en(en),
  .quiet(quiet), .armed(armed), .win_open(win_open), .do_clear(do_clear),
  .bad1(bad1), .bad2(bad2), .evt(evt), .rst_req(rst_req),
  .rst_cause(rst_cause)
);

// File: tb/test_fetch_deadman.sv
module test_fetch_deadman;
  localparam int P = 12;
  localparam int W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_stb = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic [7:0]  rst_cause;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  fetch_deadman #(.CNT_W(8), .PERIOD(P), .WINDOW(W)) i_fetch_deadman (
    .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .rst_cause(rst_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic fetch(input int n);
    for (int i = 0; i < n; i++) begin
      fetch_stb = 1'b1;
      @(negedge clk);
    end
    fetch_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic start_armed();
    do_reset();
    do_wr(8'h00, 32'h8000);
    do_wr(8'h10, 32'h4000);
  endtask

  initial begin
    #1500000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] bad_keys [6] = '{8'h00, 8'h3F, 8'h41, 8'h80, 8'hC0, 8'hFF};
    @(negedge clk);
    do_reset();
    // R1 reset state
    do_rd(8'h00, rv); check("R1 ctrl", rv, 0);
    do_rd(8'h30, rv); check("R1 status", rv, 0);
    do_rd(8'h40, rv); check("R1 count", rv, 0);
    check("R1 rst_req", {31'b0, rst_req}, 0);
    check("R1 rst_cause", {24'b0, rst_cause}, 0);
    // R11 parameter readback
    do_rd(8'h60, rv); check("R11 period", rv, P);
    do_rd(8'h70, rv); check("R11 window", rv, W);

    // R2 and R12: disabled block ignores fetches and keys
    fetch(5);
    do_rd(8'h40, rv); check("R2 disabled count", rv, 0);
    do_wr(8'h20, 32'h08);
    do_wr(8'h10, 32'h0000);
    do_rd(8'h30, rv); check("R12 keys ignored", rv, 0);
    check("R12 rst_req", {31'b0, rst_req}, 0);

    // R4 control and aliases
    do_wr(8'h04, 32'h8000);
    do_rd(8'h00, rv); check("R4 set alias", rv, 32'h8000);
    do_wr(8'h08, 32'h7FFF);
    do_rd(8'h00, rv); check("R4 clear alias other bits", rv, 32'h8000);
    do_wr(8'h00, 32'h0000);
    idle(1);
    do_rd(8'h00, rv); check("R4 plain write", rv, 0);
    do_wr(8'h00, 32'h8000);
    do_rd(8'h00, rv); check("R4 plain enable", rv, 32'h8000);

    // R10 quiet cycle after disable
    do_wr(8'h08, 32'h8000);
    do_rd(8'h60, rv); check("R10 read in quiet", rv, 0);
    do_wr(8'h04, 32'h8000);
    do_rd(8'h00, rv); check("R10 write in quiet ignored", rv, 0);
    do_rd(8'h60, rv); check("R10 read after quiet", rv, P);

    // R2, R6 sweep over every count with first key held
    start_armed();
    do_rd(8'h30, rv); check("R5 good key no error", rv, 0);
    for (int n = 0; n < P; n++) begin
      do_rd(8'h40, rv); check("R2 sweep count", rv, n);
      do_rd(8'h30, rv); check("R6 window bit", rv, (n >= P - W) ? 1 : 0);
      fetch(1);
    end
    // R3 timeout timing and freeze
    do_rd(8'h40, rv); check("R3 reached period", rv, P);
    check("R3 no request yet", {31'b0, rst_req}, 0);
    idle(1);
    check("R3 rst_req", {31'b0, rst_req}, 1);
    check("R3 rst_cause", {24'b0, rst_cause}, 32'h20);
    fetch(3);
    do_rd(8'h40, rv); check("R3 frozen", rv, P);
    do_rd(8'h30, rv); check("R3 event flag", rv & 32'hE0, 32'h20);

    // R7 correct clear, R2 hold in gaps
    start_armed();
    fetch(9);
    idle(3);
    do_rd(8'h40, rv); check("R2 hold in gap", rv, 9);
    do_wr(8'h20, 32'h08);
    do_rd(8'h40, rv); check("R7 count cleared", rv, 0);
    do_rd(8'h30, rv); check("R7 status clean", rv, 0);
    fetch(9);
    do_rd(8'h30, rv); check("R7 key discarded", rv, 0);
    // R8 second key without first
    do_wr(8'h20, 32'h08);
    do_rd(8'h30, rv); check("R8 no first key", rv & 32'hE0, 32'h60);
    check("R8 rst_req", {31'b0, rst_req}, 1);

    // R8 wrong value in window
    start_armed();
    fetch(10);
    do_wr(8'h20, 32'h09);
    do_rd(8'h30, rv); check("R8 wrong value", rv & 32'hE0, 32'h60);
    // R8 closed window
    start_armed();
    fetch(2);
    do_wr(8'h20, 32'h08);
    do_rd(8'h30, rv); check("R8 window closed", rv, 32'h60);
    fetch(2);
    do_rd(8'h40, rv); check("R8 count frozen", rv, 2);

    // R5 wrong first keys
    foreach (bad_keys[k]) begin
      do_reset();
      do_wr(8'h00, 32'h8000);
      do_wr(8'h10, {16'h0, bad_keys[k], 8'h00});
      do_rd(8'h30, rv); check("R5 bad first key", rv, 32'hA0);
      check("R5 rst_req", {31'b0, rst_req}, 1);
    end
    do_reset();
    do_wr(8'h00, 32'h8000);
    do_wr(8'h10, 32'hFFFF_40FF);
    do_rd(8'h30, rv); check("R5 junk bits ignored", rv, 0);

    // R9 sticky flags
    do_wr(8'h10, 32'h1100);
    do_wr(8'h20, 32'h00);
    do_wr(8'h08, 32'h8000);
    idle(2);
    do_wr(8'h04, 32'h8000);
    do_wr(8'h10, 32'h4000);
    idle(3);
    do_rd(8'h30, rv); check("R9 flags sticky", rv & 32'hE0, 32'hE0);
    do_reset();
    do_rd(8'h30, rv); check("R9 reset clears", rv, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule